// File: doc/BRIEF.md
# External CPU Bus Master Controller

This block lets a host take over the memory bus of an 8-bit CPU and reach the CPU's memory on its own. It requests the bus from the CPU with an active-low hold request and waits for an active-low acknowledge. It enables its own address and data drivers only while it holds the bus. Once it has the bus it runs single-byte reads and writes, and burst writes, on the memory strobes. It can also pulse the CPU's reset line for a fixed 10 µs.

Commands arrive on a valid/ready port that carries an opcode, a 19-bit address, a byte and a 16-bit length. Every command ends with a one-cycle response that carries an error flag and, for reads, the byte read. A burst either repeats one byte (fill) or takes a new byte per write from a streaming source port (copy). The memory-select strobe stays low across the whole burst, and the address counts up by one per byte.

Top module: `cpu_bus_master`

## Requirements
- R1: After reset: cpu_reset_n=0, hold_req_n=1, mem_sel_n=1, read_n=1, write_n=1, addr_oe=0, data_oe=0, cmd_ready=1.
- R2: A command is taken in a cycle where cmd_valid and cmd_ready are both 1. cmd_ready stays 0 until the command has finished, including the whole wait for the acknowledge. Each command ends with exactly one cycle of rsp_valid=1. Opcodes: 0 acquire, 1 release, 2 write, 3 read, 4 fill, 5 copy, 6 reset pulse, 7 undefined.
- R3: Acquire drives hold_req_n low and sets addr_oe only after hold_ack_n has been seen low through a two-stage synchronizer. addr_oe is never 1 while hold_req_n is 1. Acquire while the bus is already owned responds at once with rsp_err=0.
- R4: Release clears data_oe, then clears addr_oe one cycle later, then raises hold_req_n one cycle after that. It responds only after hold_ack_n has been seen high.
- R5: Write presents the address, then lowers mem_sel_n with data_oe=1 and the byte on data_out, then holds write_n low for exactly one cycle, then raises mem_sel_n. write_n is low only while mem_sel_n=0 and data_oe=1.
- R6: Read presents the address, lowers mem_sel_n with data_oe=0, and holds read_n low for exactly two cycles. It samples data_in in the last of those cycles and returns that byte on rsp_data.
- R7: Fill with length N>0 lowers mem_sel_n once and gives N one-cycle write pulses of cmd_data at addresses cmd_addr, cmd_addr+1, and so on. mem_sel_n rises only after the last pulse.
- R8: Copy behaves like fill, but each byte is taken from src_byte. src_take pulses once per byte, in the cycle the byte is captured, and only while mem_sel_n=0.
- R9: A fill or copy with length 0 gives no write pulse and no mem_sel_n low. It responds with rsp_err=0.
- R10: A write, read, fill or copy issued while the bus is not owned responds with rsp_err=1 and drives no strobe. mem_sel_n is low only while addr_oe=1.
- R11: The reset-pulse command drives cpu_reset_n low for exactly CLK_FREQ_HZ/100000 clock cycles, then drives it high and responds in that same cycle.
- R12: Opcode 7 responds with rsp_err=1 and leaves bus ownership and all bus outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 3 | Opcode (see R2) |
| cmd_addr | input | ADDR_W | Start address |
| cmd_data | input | DATA_W | Write byte or fill byte |
| cmd_len | input | LEN_W | Burst length in bytes |
| src_byte | input | DATA_W | Next byte for a copy burst |
| src_take | output | 1 | src_byte captured this cycle |
| rsp_valid | output | 1 | Command finished (one cycle) |
| rsp_err | output | 1 | Command refused |
| rsp_data | output | DATA_W | Byte returned by a read |
| addr_out | output | ADDR_W | Address bus value |
| addr_oe | output | 1 | Address driver enable |
| data_out | output | DATA_W | Data bus value when driving |
| data_in | input | DATA_W | Data bus value when receiving |
| data_oe | output | 1 | Data driver enable |
| mem_sel_n | output | 1 | Memory select strobe, active low |
| read_n | output | 1 | Read strobe, active low |
| write_n | output | 1 | Write strobe, active low |
| cpu_reset_n | output | 1 | CPU reset, active low |
| hold_req_n | output | 1 | Bus request to CPU, active low |
| hold_ack_n | input | 1 | Bus grant from CPU, active low |

## Verification
The bench holds the acknowledge back for several cycles after the request. A design that enabled the address drivers or accepted a new command during that wait would show it at the ports. During release it checks that both driver enables are already off at the moment the request is withdrawn; a wrong order would drive against the CPU. Bursts are checked for a single select fall, the exact pulse count and the exact end address, so an off-by-one length or a select that toggled per byte fails. A zero length, memory commands issued while the bus is not owned, and the undefined opcode all have to produce no strobe. The read strobe width and the reset pulse width are counted in cycles, so a strobe or pulse that is one cycle short or long is reported.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    typedef enum logic [2:0] {
        OP_GRAB     = 3'd0,
        OP_FREE     = 3'd1,
        OP_WRITE    = 3'd2,
        OP_READ     = 3'd3,
        OP_FILL     = 3'd4,
        OP_COPY     = 3'd5,
        OP_RSTPULSE = 3'd6,
        OP_NONE     = 3'd7
    } cbm_op_e;

    typedef enum logic [4:0] {
        S_IDLE,
        S_GRANT,
        S_FREE_A,
        S_FREE_H,
        S_FREE_W,
        S_WSEL,
        S_WLO,
        S_WHI,
        S_MEND,
        S_RSEL,
        S_RLO1,
        S_RLO2,
        S_RSAMP,
        S_BDAT,
        S_BLO,
        S_BHI,
        S_RPUL
    } cbm_state_e;

endpackage

// File: rtl/cbm_sync.sv
module cbm_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= {STAGES{INIT}};
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/cbm_pulse_timer.sv
module cbm_pulse_timer #(
    parameter int CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic zero
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = CW'(CYCLES - 1);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/cpu_bus_master.sv
module cpu_bus_master
    import cbm_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int DATA_W      = 8,
    parameter int LEN_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int CLK_FREQ_HZ = 250_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [DATA_W-1:0] src_byte,
    output logic              src_take,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_oe,
    output logic [DATA_W-1:0] data_out,
    input  logic [DATA_W-1:0] data_in,
    output logic              data_oe,
    output logic              mem_sel_n,
    output logic              read_n,
    output logic              write_n,
    output logic              cpu_reset_n,
    output logic              hold_req_n,
    input  logic              hold_ack_n
);
    localparam int PULSE_CYC = (CLK_FREQ_HZ / 100_000 < 1) ? 1 : CLK_FREQ_HZ / 100_000;

    typedef struct packed {
        cbm_state_e        st;
        cbm_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LEN_W-1:0]  cnt;
        logic              aoe;
        logic              doe;
        logic              msel_n;
        logic              rd_n;
        logic              wr_n;
        logic              crst_n;
        logic              hreq_n;
        logic              owned;
        logic              rsp_v;
        logic              rsp_e;
        logic [DATA_W-1:0] rsp_d;
    } regs_t;

    localparam regs_t RST_VAL = '{
        st: S_IDLE, op: OP_GRAB, addr: '0, data: '0, cnt: '0,
        aoe: 1'b0, doe: 1'b0, msel_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
        crst_n: 1'b0, hreq_n: 1'b1, owned: 1'b0,
        rsp_v: 1'b0, rsp_e: 1'b0, rsp_d: '0
    };

    regs_t   r_d, r_q;
    logic    ack_s;
    logic    tmr_load;
    logic    tmr_zero;
    logic    mem_cmd;
    cbm_op_e op_in;

    cbm_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) i_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (hold_ack_n),
        .q     (ack_s)
    );

    cbm_pulse_timer #(.CYCLES(PULSE_CYC)) i_rst_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .zero  (tmr_zero)
    );

    assign op_in   = cbm_op_e'(cmd_op);
    assign mem_cmd = (op_in == OP_WRITE) || (op_in == OP_READ) ||
                     (op_in == OP_FILL)  || (op_in == OP_COPY);

    always_comb begin
        r_d      = r_q;
        r_d.rsp_v = 1'b0;
        tmr_load = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    r_d.op    = op_in;
                    r_d.rsp_e = 1'b0;
                    if (mem_cmd && !r_q.owned) begin
                        r_d.rsp_v = 1'b1;
                        r_d.rsp_e = 1'b1;
                    end else begin
                        unique case (op_in)
                            OP_GRAB: begin
                                if (r_q.owned) r_d.rsp_v = 1'b1;
                                else begin
                                    r_d.hreq_n = 1'b0;
                                    r_d.st     = S_GRANT;
                                end
                            end
                            OP_FREE: begin
                                r_d.doe = 1'b0;
                                r_d.st  = S_FREE_A;
                            end
                            OP_WRITE: begin
                                r_d.addr = cmd_addr;
                                r_d.data = cmd_data;
                                r_d.st   = S_WSEL;
                            end
                            OP_READ: begin
                                r_d.addr = cmd_addr;
                                r_d.doe  = 1'b0;
                                r_d.st   = S_RSEL;
                            end
                            OP_FILL, OP_COPY: begin
                                if (cmd_len == '0) r_d.rsp_v = 1'b1;
                                else begin
                                    r_d.addr   = cmd_addr;
                                    r_d.data   = cmd_data;
                                    r_d.cnt    = cmd_len;
                                    r_d.doe    = 1'b1;
                                    r_d.msel_n = 1'b0;
                                    r_d.st     = S_BDAT;
                                end
                            end
                            OP_RSTPULSE: begin
                                r_d.crst_n = 1'b0;
                                tmr_load   = 1'b1;
                                r_d.st     = S_RPUL;
                            end
                            default: begin
                                r_d.rsp_v = 1'b1;
                                r_d.rsp_e = 1'b1;
                            end
                        endcase
                    end
                end
            end
            S_GRANT: begin
                if (!ack_s) begin
                    r_d.aoe   = 1'b1;
                    r_d.owned = 1'b1;
                    r_d.rsp_v = 1'b1;
                    r_d.st    = S_IDLE;
                end
            end
            S_FREE_A: begin
                r_d.aoe = 1'b0;
                r_d.st  = S_FREE_H;
            end
            S_FREE_H: begin
                r_d.hreq_n = 1'b1;
                r_d.owned  = 1'b0;
                r_d.st     = S_FREE_W;
            end
            S_FREE_W: begin
                if (ack_s) begin
                    r_d.rsp_v = 1'b1;
                    r_d.st    = S_IDLE;
                end
            end
            S_WSEL: begin
                r_d.msel_n = 1'b0;
                r_d.doe    = 1'b1;
                r_d.st     = S_WLO;
            end
            S_WLO: begin
                r_d.wr_n = 1'b0;
                r_d.st   = S_WHI;
            end
            S_WHI: begin
                r_d.wr_n = 1'b1;
                r_d.st   = S_MEND;
            end
            S_MEND: begin
                r_d.msel_n = 1'b1;
                r_d.doe    = 1'b0;
                r_d.rsp_v  = 1'b1;
                r_d.st     = S_IDLE;
            end
            S_RSEL: begin
                r_d.msel_n = 1'b0;
                r_d.st     = S_RLO1;
            end
            S_RLO1: begin
                r_d.rd_n = 1'b0;
                r_d.st   = S_RLO2;
            end
            S_RLO2: r_d.st = S_RSAMP;
            S_RSAMP: begin
                r_d.rsp_d = data_in;
                r_d.rd_n  = 1'b1;
                r_d.st    = S_MEND;
            end
            S_BDAT: begin
                if (r_q.op == OP_COPY) r_d.data = src_byte;
                r_d.st = S_BLO;
            end
            S_BLO: begin
                r_d.wr_n = 1'b0;
                r_d.st   = S_BHI;
            end
            S_BHI: begin
                r_d.wr_n = 1'b1;
                if (r_q.cnt == LEN_W'(1)) r_d.st = S_MEND;
                else begin
                    r_d.cnt  = r_q.cnt - 1'b1;
                    r_d.addr = r_q.addr + 1'b1;
                    r_d.st   = S_BDAT;
                end
            end
            S_RPUL: begin
                if (tmr_zero) begin
                    r_d.crst_n = 1'b1;
                    r_d.rsp_v  = 1'b1;
                    r_d.st     = S_IDLE;
                end
            end
            default: r_d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    assign cmd_ready   = (r_q.st == S_IDLE);
    assign src_take    = (r_q.st == S_BDAT) && (r_q.op == OP_COPY);
    assign rsp_valid   = r_q.rsp_v;
    assign rsp_err     = r_q.rsp_e;
    assign rsp_data    = r_q.rsp_d;
    assign addr_out    = r_q.addr;
    assign addr_oe     = r_q.aoe;
    assign data_out    = r_q.data;
    assign data_oe     = r_q.doe;
    assign mem_sel_n   = r_q.msel_n;
    assign read_n      = r_q.rd_n;
    assign write_n     = r_q.wr_n;
    assign cpu_reset_n = r_q.crst_n;
    assign hold_req_n  = r_q.hreq_n;

    // R3: drivers switch on only after the synchronized grant is low
    assert_grant_before_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_oe) |-> !ack_s);
    assert_drive_needs_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oe |-> !hold_req_n);
    // R4: enables are off before the request is withdrawn
    assert_release_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_req_n) |-> (!addr_oe && !data_oe));
    assert_data_off_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_oe) |-> !data_oe);
    // R5: write strobe is one cycle wide, inside select, with data driven
    assert_write_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !write_n |=> write_n);
    assert_write_framed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !write_n |-> (!mem_sel_n && data_oe));
    // R6: read strobe lasts at least two cycles with the data bus released
    assert_read_two_cycles_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(read_n) |=> !read_n);
    assert_read_framed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !read_n |-> (!mem_sel_n && !data_oe));
    // R8: source bytes are consumed only inside an open burst
    assert_take_in_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        src_take |-> !mem_sel_n);
    // R10: no memory strobe without the address drivers on
    assert_select_needs_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_sel_n |-> addr_oe);
    // R11: CPU reset is released only when the pulse timer has run out
    assert_reset_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_reset_n) |-> tmr_zero);
endmodule

// File: tb/test_cpu_bus_master.sv
module test_cpu_bus_master;
    localparam int PULSE = 250_000_000 / 100_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [18:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic [15:0] cmd_len = '0;
    logic [7:0]  src_byte;
    logic        src_take;
    logic        rsp_valid, rsp_err;
    logic [7:0]  rsp_data;
    logic [18:0] addr_out;
    logic        addr_oe;
    logic [7:0]  data_out;
    logic [7:0]  data_in;
    logic        data_oe, mem_sel_n, read_n, write_n, cpu_reset_n, hold_req_n;
    logic        hold_ack_n = 1'b1;

    int checks = 0;
    int fails  = 0;

    logic [7:0]   mem [0:255];
    logic [255:0] mem_ok = '0;
    logic [7:0]   src_mem [0:15];
    int           src_idx = 0;
    int           wr_cnt = 0;
    int           falls = 0;
    int           takes = 0;
    int           rd_run = 0;
    int           rd_last = 0;
    logic         msel_prev = 1'b1;
    logic [10:0]  hi_last = '0;

    logic        got_err;
    logic [7:0]  got_data;

    always #2 clk = ~clk;

    cpu_bus_master i_cpu_bus_master (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_len(cmd_len),
        .src_byte(src_byte), .src_take(src_take),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .addr_out(addr_out), .addr_oe(addr_oe), .data_out(data_out),
        .data_in(data_in), .data_oe(data_oe), .mem_sel_n(mem_sel_n),
        .read_n(read_n), .write_n(write_n), .cpu_reset_n(cpu_reset_n),
        .hold_req_n(hold_req_n), .hold_ack_n(hold_ack_n)
    );

    // memory model: unwritten bytes read as low address byte xor A5
    assign data_in  = mem_ok[addr_out[7:0]] ? mem[addr_out[7:0]] : (addr_out[7:0] ^ 8'hA5);
    assign src_byte = src_mem[src_idx[3:0]];

    always @(posedge clk) begin
        if (!write_n && !mem_sel_n) begin
            mem[addr_out[7:0]]    <= data_out;
            mem_ok[addr_out[7:0]] <= 1'b1;
            hi_last               <= addr_out[18:8];
            wr_cnt                <= wr_cnt + 1;
        end
        if (src_take) begin
            src_idx <= src_idx + 1;
            takes   <= takes + 1;
        end
        if (msel_prev && !mem_sel_n) falls <= falls + 1;
        msel_prev <= mem_sel_n;
        if (!read_n) rd_run <= rd_run + 1;
        else if (rd_run != 0) begin
            rd_last <= rd_run;
            rd_run  <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic [18:0] a, input logic [7:0] d, input logic [15:0] l);
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_data = d; cmd_len = l; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_rsp(input string req);
        int n = 0;
        while (!rsp_valid && n < 10000) begin
            @(negedge clk);
            n++;
        end
        chk(rsp_valid, req, "response arrived", int'(rsp_valid), 1);
        got_err  = rsp_err;
        got_data = rsp_data;
    endtask

    task automatic t_reset_state();
        chk(cpu_reset_n == 1'b0, "R1", "cpu_reset_n", int'(cpu_reset_n), 0);
        chk(hold_req_n == 1'b1 && mem_sel_n == 1'b1 && read_n == 1'b1 && write_n == 1'b1,
            "R1", "strobes idle", int'({hold_req_n, mem_sel_n, read_n, write_n}), 15);
        chk(!addr_oe && !data_oe, "R1", "driver enables", int'({addr_oe, data_oe}), 0);
        chk(cmd_ready == 1'b1, "R1", "cmd_ready", int'(cmd_ready), 1);
    endtask

    task automatic t_unowned();
        int w0 = wr_cnt, f0 = falls;
        send(3'd2, 19'h00020, 8'h11, 16'd0);
        wait_rsp("R10");
        chk(got_err == 1'b1, "R10", "write unowned err", int'(got_err), 1);
        send(3'd4, 19'h00020, 8'h11, 16'd3);
        wait_rsp("R10");
        chk(got_err == 1'b1, "R10", "fill unowned err", int'(got_err), 1);
        chk(wr_cnt == w0 && falls == f0, "R10", "no strobes", wr_cnt - w0 + falls - f0, 0);
    endtask

    task automatic t_acquire();
        send(3'd0, '0, '0, '0);
        repeat (5) begin
            @(negedge clk);
            chk(!cmd_ready && !hold_req_n && !addr_oe && !rsp_valid, "R3",
                "busy waiting for grant", int'({cmd_ready, hold_req_n, addr_oe, rsp_valid}), 0);
        end
        hold_ack_n = 1'b0;
        wait_rsp("R3");
        chk(got_err == 1'b0 && addr_oe == 1'b1, "R3", "owned after grant", int'({got_err, addr_oe}), 1);
        // R2: single-cycle response
        @(negedge clk);
        chk(rsp_valid == 1'b0 && cmd_ready == 1'b1, "R2", "response one cycle", int'({rsp_valid, cmd_ready}), 1);
        send(3'd0, '0, '0, '0);
        wait_rsp("R3");
        chk(got_err == 1'b0 && hold_req_n == 1'b0 && addr_oe == 1'b1, "R3",
            "re-acquire no change", int'({got_err, hold_req_n, addr_oe}), 1);
    endtask

    task automatic t_write();
        int w0 = wr_cnt, f0 = falls;
        send(3'd2, 19'h71234, 8'h5A, 16'd0);
        wait_rsp("R5");
        chk(got_err == 1'b0, "R5", "write err", int'(got_err), 0);
        chk(mem[8'h34] == 8'h5A, "R5", "written byte", int'(mem[8'h34]), 'h5A);
        chk(hi_last == 11'h712, "R5", "upper address", int'(hi_last), 'h712);
        chk(wr_cnt - w0 == 1 && falls - f0 == 1, "R5", "one pulse one select",
            (wr_cnt - w0) * 10 + falls - f0, 11);
        chk(mem_sel_n == 1'b1 && data_oe == 1'b0, "R5", "select closed", int'({mem_sel_n, data_oe}), 2);
    endtask

    task automatic t_read();
        send(3'd3, 19'h00034, 8'h00, 16'd0);
        wait_rsp("R6");
        chk(got_data == 8'h5A, "R6", "read written byte", int'(got_data), 'h5A);
        @(negedge clk);
        chk(rd_last == 2, "R6", "read strobe width", rd_last, 2);
        send(3'd3, 19'h5003C, 8'h00, 16'd0);
        wait_rsp("R6");
        chk(got_data == 8'h99 && got_err == 1'b0, "R6", "read unwritten byte", int'(got_data), 'h99);
    endtask

    task automatic t_fill();
        int w0 = wr_cnt, f0 = falls;
        send(3'd4, 19'h30010, 8'hEE, 16'd5);
        wait_rsp("R7");
        for (int i = 0; i < 5; i++)
            chk(mem[8'h10 + i] == 8'hEE, "R7", "fill byte", int'(mem[8'h10 + i]), 'hEE);
        chk(mem_ok[8'h15] == 1'b0, "R7", "no write past end", int'(mem_ok[8'h15]), 0);
        chk(wr_cnt - w0 == 5, "R7", "pulse count", wr_cnt - w0, 5);
        chk(falls - f0 == 1, "R7", "select held across burst", falls - f0, 1);
        chk(hi_last == 11'h300, "R7", "upper address", int'(hi_last), 'h300);
    endtask

    task automatic t_copy();
        int w0 = wr_cnt, f0 = falls, t0 = takes, s0 = src_idx;
        for (int i = 0; i < 16; i++) src_mem[i] = 8'(8'h30 + 7 * i);
        send(3'd5, 19'h00080, 8'h00, 16'd4);
        wait_rsp("R8");
        for (int i = 0; i < 4; i++)
            chk(mem[8'h80 + i] == src_mem[(s0 + i) % 16], "R8", "copied byte",
                int'(mem[8'h80 + i]), int'(src_mem[(s0 + i) % 16]));
        chk(takes - t0 == 4, "R8", "source takes", takes - t0, 4);
        chk(wr_cnt - w0 == 4 && falls - f0 == 1, "R8", "pulses and select",
            (wr_cnt - w0) * 10 + falls - f0, 41);
    endtask

    task automatic t_zero_len();
        int w0 = wr_cnt, f0 = falls, t0 = takes;
        send(3'd4, 19'h00050, 8'h77, 16'd0);
        wait_rsp("R9");
        chk(got_err == 1'b0, "R9", "fill zero err", int'(got_err), 0);
        send(3'd5, 19'h00050, 8'h77, 16'd0);
        wait_rsp("R9");
        chk(got_err == 1'b0, "R9", "copy zero err", int'(got_err), 0);
        chk(wr_cnt == w0 && falls == f0 && takes == t0, "R9", "no activity",
            wr_cnt - w0 + falls - f0 + takes - t0, 0);
    endtask

    task automatic t_bad_op();
        int w0 = wr_cnt;
        send(3'd7, 19'h00001, 8'h01, 16'd1);
        wait_rsp("R12");
        chk(got_err == 1'b1, "R12", "undefined op err", int'(got_err), 1);
        chk(addr_oe && !hold_req_n && mem_sel_n && wr_cnt == w0, "R12", "bus unchanged",
            int'({addr_oe, hold_req_n, mem_sel_n}), 5);
    endtask

    task automatic t_release();
        int n = 0;
        send(3'd1, '0, '0, '0);
        while (!hold_req_n && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(hold_req_n == 1'b1, "R4", "request withdrawn", int'(hold_req_n), 1);
        chk(!addr_oe && !data_oe, "R4", "enables off before", int'({addr_oe, data_oe}), 0);
        repeat (4) begin
            @(negedge clk);
            chk(!rsp_valid && !cmd_ready, "R4", "waits for grant high", int'({rsp_valid, cmd_ready}), 0);
        end
        hold_ack_n = 1'b1;
        wait_rsp("R4");
        chk(got_err == 1'b0, "R4", "release err", int'(got_err), 0);
        send(3'd3, 19'h00034, '0, '0);
        wait_rsp("R10");
        chk(got_err == 1'b1, "R10", "read after release err", int'(got_err), 1);
    endtask

    task automatic t_reset_pulse();
        int low = 0;
        int n = 0;
        send(3'd6, '0, '0, '0);
        // accept edge already passed; count low cycles until release
        while (!cpu_reset_n && n < 10000) begin
            low++;
            n++;
            @(negedge clk);
        end
        chk(low == PULSE, "R11", "reset pulse width", low, PULSE);
        chk(rsp_valid == 1'b1 && cpu_reset_n == 1'b1, "R11", "response with release",
            int'({rsp_valid, cpu_reset_n}), 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_unowned();
        t_acquire();
        t_write();
        t_read();
        t_fill();
        t_copy();
        t_zero_len();
        t_bad_op();
        t_release();
        t_reset_pulse();
        t_reset_pulse();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule